// File: doc/BRIEF.md
# Monochrome Bitmap Raster Engine with Word Fetch

This block produces the raster timing for a VGA-compatible monitor from a single system clock and paints a one-bit-per-pixel bitmap taken from memory. Each system clock carries two pixels: one while the clock is high and one while it is low. With the default settings this gives 576 visible pixels per line and 455 visible lines. Every visible line is split into 16-pixel words. The block asks for each word with a request/acknowledge pair, keeps a word address that advances on every acknowledge, and sets that address back to zero once per frame.

The line and frame positions are held in two linear feedback shift registers, not in binary counters. Each one returns to its seed after a programmed number of states. Four pattern comparators on each register set and clear four span flags: horizontal enable, horizontal sync, vertical enable and vertical sync. A fetched word waits in a staging register. It is then moved into an eight-stage, two-bit-wide shifter, and a clock-phase multiplexer drives all six colour outputs from a single bit.

The word fetcher is a two-state machine. In FETCH_IDLE, a word strobe (the first clock of an eight-clock group inside the visible window) moves it to FETCH_WAIT. In FETCH_WAIT, an acknowledge latches the data, advances the address and returns it to FETCH_IDLE. In every other case the machine stays where it is.

Top module: `mono_vga_dma`

## Requirements
- R1: While rst_n is low: hsync_n and vsync_n are 1, dma_req is 0, dma_addr is 0 and rgb is 0 in both clock phases.
- R2: Number the cycles of a line from 0, with the first cycle after reset as position 0. The line is H_TOTAL cycles long (default 381). hsync_n is 0 exactly at positions H_SYNC_ON to H_SYNC_OFF-1 (default 308 to 352).
- R3: A frame is V_TOTAL lines (default 528), starting at line 0 after reset. vsync_n is 0 for every cycle of lines V_SYNC_ON to V_SYNC_OFF-1 (default 486 to 487).
- R4: On a visible line (line < V_ACTIVE), dma_req rises in the cycle after each position 8k with 8k < H_ACTIVE, and never at any other time. Once high, it stays high until a cycle in which dma_ack is 1, and it is 0 in the following cycle. A frame has exactly V_ACTIVE*H_ACTIVE/8 requests.
- R5: Each cycle with dma_req and dma_ack both 1 increments dma_addr by one, wrapping modulo 2^ADDR_W.
- R6: dma_addr is 0 in the first cycle of every frame (line 0, position 0).
- R7: The word acknowledged for group k of a visible line is shown at positions 8k+8 to 8k+15. At position 8k+8+j, the high clock phase shows word bit 15-2j and the low phase shows bit 14-2j. An acknowledge may come 1 to 5 cycles after dma_req rises.
- R8: All six rgb bits carry the same pixel value. Outside the visible window (visible lines, positions 8 to H_ACTIVE+7) rgb is 0.
- R9: dma_ack while dma_req is 0 is ignored: dma_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its level also selects the pixel phase |
| rst_n | input | 1 | Active-low reset |
| dma_ack | input | 1 | Memory has returned the requested word |
| dma_data | input | WORD_W | Word returned with dma_ack |
| dma_req | output | 1 | Word fetch request |
| dma_addr | output | ADDR_W | Word address of the pending fetch |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 6 | Colour bits, all driven by the current pixel |

## Verification
Both sync outputs are registered and change in the same cycle as the line position they mark. The bench therefore counts cycles from reset release and compares the syncs in that cycle. dma_req rises one cycle after the word strobe, and dma_addr moves one cycle after the acknowledging cycle. The bench records acknowledges at the low-phase sample and checks the address at the next high-phase sample. A word's pixels appear eight positions after its group starts, so every cycle is sampled in both clock phases against a bit taken from the bench's own memory model. The acknowledge delay is varied from 1 to 5 cycles, and a narrow address width makes the address wrap within a frame.

// File: rtl/vga_pkg.sv
package vga_pkg;

    typedef enum logic [0:0] {
        FETCH_IDLE = 1'b0,
        FETCH_WAIT = 1'b1
    } fetch_state_t;

    // Feedback tap mask for a maximal-length shift-left LFSR of width w.
    function automatic logic [15:0] lfsr_mask(input int w);
        logic [15:0] m;
        case (w)
            4:       m = 16'h000C;
            5:       m = 16'h0014;
            6:       m = 16'h0030;
            7:       m = 16'h0060;
            8:       m = 16'h00B8;
            9:       m = 16'h0110;
            10:      m = 16'h0240;
            11:      m = 16'h0500;
            12:      m = 16'h0829;
            13:      m = 16'h100D;
            14:      m = 16'h2015;
            15:      m = 16'h6000;
            16:      m = 16'hD008;
            default: m = 16'h0003;
        endcase
        return m;
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] s, input int w);
        logic        fb;
        logic [15:0] keep;
        fb   = ^(s & lfsr_mask(w));
        keep = (16'd1 << w) - 16'd1;
        return ((s << 1) | {15'd0, fb}) & keep;
    endfunction

    // State reached after n steps from the seed value 1.
    function automatic logic [15:0] lfsr_at(input int w, input int n);
        logic [15:0] s;
        s = 16'd1;
        for (int i = 0; i < n; i++) begin
            s = lfsr_step(s, w);
        end
        return s;
    endfunction

endpackage

// File: rtl/lfsr_timer.sv
module lfsr_timer
    import vga_pkg::*;
#(
    parameter int W      = 9,
    parameter int TOTAL  = 381,
    parameter int MARK_A = 287,
    parameter int MARK_B = 307,
    parameter int MARK_C = 352
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic hit_a,
    output logic hit_b,
    output logic hit_c,
    output logic hit_end
);

    localparam logic [15:0] PA_F = lfsr_at(W, MARK_A);
    localparam logic [15:0] PB_F = lfsr_at(W, MARK_B);
    localparam logic [15:0] PC_F = lfsr_at(W, MARK_C);
    localparam logic [15:0] PE_F = lfsr_at(W, TOTAL - 1);
    localparam logic [W-1:0] SEED  = W'(1);
    localparam logic [W-1:0] PAT_A = PA_F[W-1:0];
    localparam logic [W-1:0] PAT_B = PB_F[W-1:0];
    localparam logic [W-1:0] PAT_C = PC_F[W-1:0];
    localparam logic [W-1:0] PAT_E = PE_F[W-1:0];

    logic [W-1:0]  state_q;
    logic [15:0]   nxt_full;

    assign nxt_full = lfsr_step(16'(state_q), W);

    assign hit_a   = (state_q == PAT_A);
    assign hit_b   = (state_q == PAT_B);
    assign hit_c   = (state_q == PAT_C);
    assign hit_end = (state_q == PAT_E);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= hit_end ? SEED : nxt_full[W-1:0];
        end
    end

endmodule

// File: rtl/span_flag.sv
module span_flag #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (en) begin
            if (set_i) begin
                q <= 1'b1;
            end else if (clr_i) begin
                q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_en,
    input  logic [WORD_W-1:0] stage,
    output logic              fetch_strobe,
    output logic              pix_hi,
    output logic              pix_lo
);

    localparam int SLOTS = WORD_W / 2;
    localparam int PH_W  = $clog2(SLOTS);
    localparam logic [PH_W-1:0] LAST = PH_W'(SLOTS - 1);

    logic [PH_W-1:0]   phase_q;
    logic [PH_W-1:0]   shcnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              valid_q;
    logic              load;

    assign fetch_strobe = vid_en && (phase_q == '0);
    assign load         = vid_en && (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!vid_en) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            shcnt_q <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            sh_q    <= stage;
            shcnt_q <= '0;
            valid_q <= 1'b1;
        end else if (valid_q) begin
            sh_q    <= {sh_q[WORD_W-3:0], 2'b00};
            shcnt_q <= shcnt_q + 1'b1;
            if (shcnt_q == LAST) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign pix_hi = valid_q & sh_q[WORD_W-1];
    assign pix_lo = valid_q & sh_q[WORD_W-2];

endmodule

// File: rtl/dma_fetch.sv
module dma_fetch
    import vga_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              frame_wrap,
    input  logic              ack,
    input  logic [WORD_W-1:0] data,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] stage
);

    fetch_state_t state_q, state_d;
    logic         take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FETCH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FETCH_IDLE: if (strobe) state_d = FETCH_WAIT;
            FETCH_WAIT: if (ack)    state_d = FETCH_IDLE;
        endcase
    end

    always_comb begin
        req  = 1'b0;
        take = 1'b0;
        unique case (state_q)
            FETCH_IDLE: begin
                req  = 1'b0;
                take = 1'b0;
            end
            FETCH_WAIT: begin
                req  = 1'b1;
                take = ack;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            stage <= '0;
        end else begin
            if (take) begin
                stage <= data;
            end
            if (frame_wrap) begin
                addr <= '0;
            end else if (take) begin
                addr <= addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mono_vga_dma.sv
module mono_vga_dma
    import vga_pkg::*;
#(
    parameter int H_ACTIVE   = 288,
    parameter int H_SYNC_ON  = 308,
    parameter int H_SYNC_OFF = 353,
    parameter int H_TOTAL    = 381,
    parameter int V_ACTIVE   = 455,
    parameter int V_SYNC_ON  = 486,
    parameter int V_SYNC_OFF = 488,
    parameter int V_TOTAL    = 528,
    parameter int H_BITS     = 9,
    parameter int V_BITS     = 10,
    parameter int WORD_W     = 16,
    parameter int ADDR_W     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_ack,
    input  logic [WORD_W-1:0] dma_data,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [5:0]        rgb
);

    localparam int COLOUR_BITS = 6;

    logic h_blank_hit, h_sync_hit, h_unsync_hit, h_end;
    logic v_blank_hit, v_sync_hit, v_unsync_hit, v_end;
    logic h_en_q, v_en_q;
    logic frame_wrap, vid_en, fetch_strobe;
    logic pix_hi, pix_lo, pixel;
    logic [WORD_W-1:0] stage_w;

    lfsr_timer #(
        .W(H_BITS), .TOTAL(H_TOTAL),
        .MARK_A(H_ACTIVE - 1), .MARK_B(H_SYNC_ON - 1), .MARK_C(H_SYNC_OFF - 1)
    ) u_htim (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .hit_a(h_blank_hit), .hit_b(h_sync_hit), .hit_c(h_unsync_hit), .hit_end(h_end)
    );

    lfsr_timer #(
        .W(V_BITS), .TOTAL(V_TOTAL),
        .MARK_A(V_ACTIVE - 1), .MARK_B(V_SYNC_ON - 1), .MARK_C(V_SYNC_OFF - 1)
    ) u_vtim (
        .clk(clk), .rst_n(rst_n), .step(h_end),
        .hit_a(v_blank_hit), .hit_b(v_sync_hit), .hit_c(v_unsync_hit), .hit_end(v_end)
    );

    span_flag #(.INIT(1'b1)) u_hen (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .set_i(h_end), .clr_i(h_blank_hit), .q(h_en_q)
    );

    span_flag #(.INIT(1'b1)) u_hsync (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .set_i(h_unsync_hit), .clr_i(h_sync_hit), .q(hsync_n)
    );

    span_flag #(.INIT(1'b1)) u_ven (
        .clk(clk), .rst_n(rst_n), .en(h_end),
        .set_i(v_end), .clr_i(v_blank_hit), .q(v_en_q)
    );

    span_flag #(.INIT(1'b1)) u_vsync (
        .clk(clk), .rst_n(rst_n), .en(h_end),
        .set_i(v_unsync_hit), .clr_i(v_sync_hit), .q(vsync_n)
    );

    assign frame_wrap = h_end & v_end;
    assign vid_en     = h_en_q & v_en_q;

    pixel_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .stage(stage_w),
        .fetch_strobe(fetch_strobe), .pix_hi(pix_hi), .pix_lo(pix_lo)
    );

    dma_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .strobe(fetch_strobe), .frame_wrap(frame_wrap),
        .ack(dma_ack), .data(dma_data), .req(dma_req), .addr(dma_addr), .stage(stage_w)
    );

    always_comb begin
        pixel = clk ? pix_hi : pix_lo;
        rgb   = {COLOUR_BITS{pixel}};
    end

endmodule

// File: rtl/vga_dma_checker.sv
module vga_dma_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_req,
    input logic              dma_ack,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              frame_wrap,
    input logic              hsync_n,
    input logic [5:0]        rgb
);

    logic [ADDR_W-1:0] addr_inc;
    assign addr_inc = dma_addr + 1'b1;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack |=> dma_req);                                   // R4
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack |=> !dma_req);                                   // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && !frame_wrap |=> dma_addr == $past(addr_inc)); // R5
    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> dma_addr == '0);                                     // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_req && dma_ack) && !frame_wrap |=> $stable(dma_addr));        // R9
    AST_SYNC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> rgb == '0);                                            // R8

endmodule

bind mono_vga_dma vga_dma_checker #(.ADDR_W(ADDR_W)) u_check (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_addr(dma_addr), .frame_wrap(frame_wrap), .hsync_n(hsync_n), .rgb(rgb)
);

// File: tb/mono_vga_dma_test.sv
module mono_vga_dma_test;

    localparam int HA = 16, HS_ON = 26, HS_OFF = 29, HT = 32;
    localparam int VA = 6, VS_ON = 8, VS_OFF = 9, VT = 11;
    localparam int AW = 3;
    localparam int WORDS_PER_FRAME = VA * HA / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          dma_ack = 1'b0;
    logic [15:0]   dma_data = '0;
    logic          dma_req, hsync_n, vsync_n;
    logic [AW-1:0] dma_addr;
    logic [5:0]    rgb;
    logic          req_f, hs_f, vs_f;
    logic [13:0]   addr_f;
    logic [5:0]    rgb_f;

    mono_vga_dma #(
        .H_ACTIVE(HA), .H_SYNC_ON(HS_ON), .H_SYNC_OFF(HS_OFF), .H_TOTAL(HT),
        .V_ACTIVE(VA), .V_SYNC_ON(VS_ON), .V_SYNC_OFF(VS_OFF), .V_TOTAL(VT),
        .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .dma_ack(dma_ack), .dma_data(dma_data),
        .dma_req(dma_req), .dma_addr(dma_addr), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .rgb(rgb)
    );

    mono_vga_dma uut_full (
        .clk(clk), .rst_n(rst_n), .dma_ack(1'b0), .dma_data(16'h0000),
        .dma_req(req_f), .dma_addr(addr_f), .hsync_n(hs_f),
        .vsync_n(vs_f), .rgb(rgb_f)
    );

    int   n_checks = 0;
    int   n_fails  = 0;
    int   t = 0;
    int   nreq = 0;
    bit   done = 1'b0;
    bit   spur_mode = 1'b0;
    bit   spur_on = 1'b0;
    logic prev_req = 1'b0;
    logic pend_ack = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    function automatic logic [15:0] mem(input int a);
        logic [31:0] v;
        v = ((a + 1) * 32'h0000_A5C3) ^ (a * 32'h0000_1F00);
        return v[15:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, t, act, exp);
        end
    endtask

    // Memory responder: acknowledge latency cycles through 1..5.
    initial begin
        int wait_cnt = 0;
        int nword = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                dma_ack  = 1'b0;
                wait_cnt = 0;
            end else if (dma_ack) begin
                dma_ack = 1'b0;
            end else if (dma_req) begin
                if (wait_cnt >= (nword % 5)) begin
                    dma_data = mem(int'(dma_addr));
                    dma_ack  = 1'b1;
                    wait_cnt = 0;
                    nword++;
                end else begin
                    wait_cnt++;
                end
            end else if (spur_on) begin
                dma_data = 16'hFFFF;
                dma_ack  = 1'b1;
            end
        end
    end

    task automatic step_cycle();
        int c, l, w, bp, c2, ln;
        logic [15:0] mw;
        logic exp_hi, exp_lo, in_pix, exp_hs, exp_vs, exp_hf;
        logic [AW-1:0] ea;
        string tag;
        @(posedge clk);
        t++;
        #2;
        c = t % HT;
        l = (t / HT) % VT;
        exp_hs = !(c >= HS_ON && c < HS_OFF);
        exp_vs = !(l >= VS_ON && l < VS_OFF);
        chk(hsync_n == exp_hs, "R2 hsync", hsync_n, exp_hs);
        chk(vsync_n == exp_vs, "R3 vsync", vsync_n, exp_vs);
        in_pix = (l < VA) && (c >= 8) && (c < HA + 8);
        exp_hi = 1'b0;
        exp_lo = 1'b0;
        if (in_pix) begin
            w  = l * (HA / 8) + (c - 8) / 8;
            mw = mem(w % (1 << AW));
            bp = 15 - 2 * ((c - 8) % 8);
            exp_hi = mw[bp];
            exp_lo = mw[bp - 1];
        end
        tag = in_pix ? "R7 high-phase pixel" : "R8 blank high phase";
        chk(rgb == {6{exp_hi}}, tag, rgb, {6{exp_hi}});
        ea = pend_ack ? prev_addr + 1'b1 : prev_addr;
        if (c == 0 && l == 0) begin
            ea = '0;
            chk(dma_addr == ea, "R6 frame address", dma_addr, ea);
        end else if (pend_ack) begin
            chk(dma_addr == ea, "R5 address step", dma_addr, ea);
        end else begin
            chk(dma_addr == ea, "R9 address held", dma_addr, ea);
        end
        if (dma_req && !prev_req) begin
            nreq++;
            chk((l < VA) && (c % 8 == 1) && (c < HA), "R4 request position", c, 1);
        end
        if (!dma_req && prev_req) begin
            chk(pend_ack, "R4 request drop", 0, 1);
        end
        prev_req  = dma_req;
        prev_addr = dma_addr;
        c2 = t % 381;
        exp_hf = !(c2 >= 308 && c2 < 353);
        chk(hs_f == exp_hf, "R2 default hsync", hs_f, exp_hf);
        chk(vs_f == 1'b1, "R3 default vsync", vs_f, 1);
        @(negedge clk);
        #2;
        tag = in_pix ? "R7 low-phase pixel" : "R8 blank low phase";
        chk(rgb == {6{exp_lo}}, tag, rgb, {6{exp_lo}});
        pend_ack = dma_req && dma_ack;
        ln = ((t + 1) / HT) % VT;
        spur_on = spur_mode && (ln >= VA) && (ln < VT - 1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(hsync_n == 1'b1, "R1 hsync_n", hsync_n, 1);
        chk(vsync_n == 1'b1, "R1 vsync_n", vsync_n, 1);
        chk(dma_req == 1'b0, "R1 dma_req", dma_req, 0);
        chk(dma_addr == '0, "R1 dma_addr", dma_addr, 0);
        chk(rgb == '0, "R1 rgb high phase", rgb, 0);
        @(negedge clk);
        #2;
        chk(rgb == '0, "R1 rgb low phase", rgb, 0);
        @(negedge clk);
        rst_n = 1'b1;
        t = 0;
    endtask

    task automatic test_frame(input bit spurious, input string name);
        spur_mode = spurious;
        nreq = 0;
        repeat (HT * VT) step_cycle();
        chk(nreq == WORDS_PER_FRAME, {"R4 requests per frame, ", name}, nreq, WORDS_PER_FRAME);
        spur_mode = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
            summary();
            $finish;
        end
    end

    initial begin
        test_reset();
        test_frame(1'b0, "first frame");
        test_frame(1'b1, "stray acknowledges in blanking");
        test_frame(1'b0, "third frame");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule